// File: doc/BRIEF.md
# SMBus Masked Slave Address Recognizer

This block listens to a two-wire SMBus/I2C bus as a slave. After every START or repeated START it shifts in the eight-bit address byte (seven address bits followed by the read/write bit) and decides in hardware whether the byte is meant for it. The decision compares the received address against a configured seven-bit address. The compare runs through a per-bit mask, so a single setting can accept a whole family of addresses. A separate general-call enable adds address zero on top of that family.

When hardware acknowledge is enabled, a matching address is acknowledged by pulling SDA low for the ninth clock. Every data byte that follows in a write transfer is acknowledged in the same way. An interrupt flag is raised for each accepted address byte, each received data byte and the STOP that ends an addressed transfer. The flag stays set until a one-cycle clear pulse arrives. The last byte taken from the bus is presented on a data output, with its first bit in bit 7. Both bus lines are brought into the system clock through a synchronizer, and all bus events are found by comparing edges in that clock domain.

Top module: `smb_addr_match`

## Requirements
- R1: After reset, `flag_o` is 0, `data_o` is 0x00 and `sda_pull_o` is 0 (SDA released).
- R2: With mask 0x7F and hardware acknowledge on, an address byte whose upper seven bits equal `cfg_addr_i[7:1]` is acknowledged, raises `flag_o`, and appears unchanged on `data_o` (address in bits 7:1, R/W in bit 0).
- R3: With hardware acknowledge on, an address that does not match is not acknowledged, does not raise the flag, and still appears on `data_o`. Later bytes up to the next START are neither acknowledged nor flagged, and `data_o` keeps the address byte.
- R4: A mask bit of 1 makes the matching address bit significant and a mask bit of 0 makes it don't-care. Address 0x34 with mask 0x7E accepts 0x35. Address 0x70 with mask 0x73 accepts 0x74 and 0x7C and rejects 0x71 and 0x72.
- R5: With `cfg_addr_i[0]`=1, address 0x00 is acknowledged even when the masked compare fails. With `cfg_addr_i[0]`=0, the same address is rejected.
- R6: Bits are sampled on SCL rising edges MSB first: the first data bit received ends in `data_o[7]`.
- R7: In an acknowledged write transfer, every data byte is acknowledged, raises `flag_o` and is placed on `data_o`.
- R8: With `hw_ack_en_i`=0, SDA is never pulled. Every address byte, whether or not it matches, raises the flag, and so does every data byte after it.
- R9: A STOP (SDA rising while SCL is high) raises `flag_o` when it ends a transfer in which the address byte was accepted. A STOP that ends an ignored transfer does not.
- R10: `flag_o` stays set until `flag_clr_i` is high for a cycle. A set event in the same cycle wins over the clear.
- R11: A repeated START restarts the address phase, so a matching address after it is acknowledged even when the transfer before it was ignored.
- R12: SDA is pulled only while SCL is low at the moment of change: from the SCL fall after bit 8 until the SCL fall after bit 9. It is released by the end of every byte and on a STOP.
- R13: After an accepted address with R/W=1, the block acknowledges the address and then stays quiet. Bytes clocked afterwards are not acknowledged, not flagged and do not change `data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| cfg_addr_i | input | 8 | Bits 7:1 slave address, bit 0 general-call enable |
| cfg_mask_i | input | 7 | Per-bit compare mask for the seven address bits |
| hw_ack_en_i | input | 1 | Enables address recognition and hardware acknowledge |
| flag_clr_i | input | 1 | One-cycle pulse that clears the interrupt flag |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| flag_o | output | 1 | Interrupt flag |
| data_o | output | 8 | Last byte received from the bus |

## Verification
The bench goes after the mask corners. A compare that ignores the mask would reject 0x35, 0x74 and 0x7C. A compare with the mask inverted would accept 0x71 or 0x72. A general-call path that is not gated by its enable would acknowledge 0x00 with the enable off. It also covers a non-matching address followed by data: a design that resumes after a rejected address would acknowledge or flag the data bytes. Other cases are a repeated START after an ignored address, which a design that only re-arms on STOP would miss, and a read transfer, where a design that keeps receiving would acknowledge bytes it should not. Bit order is tested with an asymmetric byte that a reversed shift would present mirrored, and the flag is left uncleared for a long wait to catch a design that drops it by itself.

// File: rtl/smb_pkg.sv
package smb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_DATA,
      ST_DATA_ACK,
      ST_HOLD
   } smb_state_e;
endpackage

// File: rtl/smb_sync_edge.sv
module smb_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_d, sda_d;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("smb_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_d  <= scl_ff[STAGES-1];
         sda_d  <= sda_ff[STAGES-1];
      end
   end

   assign scl_lvl   = scl_ff[STAGES-1];
   assign sda_lvl   = sda_ff[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_d;
   assign scl_fall  = ~scl_lvl & scl_d;
   assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/smb_addr_cmp.sv
module smb_addr_cmp #(
   parameter int ADDR_W  = 7,
   parameter bit MASK_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [ADDR_W-1:0] mask,
   input  logic              gc_en,
   output logic              hit
);
   logic [ADDR_W-1:0] bit_ok;

   generate
      if (ADDR_W < 1) begin : g_bad_width
         $error("smb_addr_cmp: ADDR_W must be positive");
      end
      if (MASK_EN) begin : g_masked
         for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
            assign bit_ok[i] = ~mask[i] | (rx_addr[i] == own_addr[i]);
         end
      end else begin : g_exact
         assign bit_ok = ~(rx_addr ^ own_addr);
      end
   endgenerate

   assign hit = (&bit_ok) | (gc_en & (rx_addr == '0));
endmodule

// File: rtl/smb_addr_match.sv
module smb_addr_match #(
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2,
   parameter bit MASK_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W:0]   cfg_addr_i,
   input  logic [ADDR_W-1:0] cfg_mask_i,
   input  logic              hw_ack_en_i,
   input  logic              flag_clr_i,
   output logic              sda_pull_o,
   output logic              flag_o,
   output logic [ADDR_W:0]   data_o
);
   import smb_pkg::*;

   localparam int BYTE_W = ADDR_W + 1;
   localparam int CNT_W  = $clog2(BYTE_W + 2);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
   logic addr_hit;

   smb_state_e        st;
   logic [CNT_W-1:0]  bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic              rw_q;

   smb_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt)
   );

   smb_addr_cmp #(.ADDR_W(ADDR_W), .MASK_EN(MASK_EN)) u_cmp (
      .rx_addr  (shreg[BYTE_W-1:1]),
      .own_addr (cfg_addr_i[BYTE_W-1:1]),
      .mask     (cfg_mask_i),
      .gc_en    (cfg_addr_i[0]),
      .hit      (addr_hit)
   );

   logic scl_lvl_unused;
   assign scl_lvl_unused = scl_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         bitcnt     <= '0;
         shreg      <= '0;
         rw_q       <= 1'b0;
         data_o     <= '0;
         flag_o     <= 1'b0;
         sda_pull_o <= 1'b0;
      end else begin
         if (flag_clr_i) flag_o <= 1'b0;
         if (start_evt) begin
            st         <= ST_ADDR;
            bitcnt     <= '0;
            sda_pull_o <= 1'b0;
         end else if (stop_evt) begin
            if (st != ST_IDLE && st != ST_ADDR) flag_o <= 1'b1;
            st         <= ST_IDLE;
            bitcnt     <= '0;
            sda_pull_o <= 1'b0;
         end else begin
            unique case (st)
               ST_ADDR, ST_DATA: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == LAST_BIT) begin
                     data_o <= shreg;
                     if (st == ST_ADDR) begin
                        rw_q <= shreg[0];
                        if (hw_ack_en_i && !addr_hit) begin
                           st <= ST_IDLE;
                        end else begin
                           flag_o     <= 1'b1;
                           sda_pull_o <= hw_ack_en_i;
                           st         <= ST_ADDR_ACK;
                        end
                     end else begin
                        flag_o     <= 1'b1;
                        sda_pull_o <= hw_ack_en_i;
                        st         <= ST_DATA_ACK;
                     end
                  end
               end
               ST_ADDR_ACK, ST_DATA_ACK: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == ACK_BIT) begin
                     sda_pull_o <= 1'b0;
                     bitcnt     <= '0;
                     st         <= (st == ST_ADDR_ACK && rw_q) ? ST_HOLD : ST_DATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/smb_addr_match_chk.sv
module smb_addr_match_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic hw_ack_en_i,
   input logic flag_clr_i,
   input logic flag_o,
   input logic sda_pull_o,
   input logic stop_evt
);
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !flag_clr_i) |=> flag_o); // R10

   AST_PULL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      sda_pull_o |-> hw_ack_en_i); // R8

   AST_PULL_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> !scl_i); // R12

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_pull_o); // R12
endmodule

bind smb_addr_match smb_addr_match_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_i       (scl_i),
   .hw_ack_en_i (hw_ack_en_i),
   .flag_clr_i  (flag_clr_i),
   .flag_o      (flag_o),
   .sda_pull_o  (sda_pull_o),
   .stop_evt    (stop_evt)
);

// File: tb/tb_smb_addr_match.sv
module tb_smb_addr_match;
   localparam int Q = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1, m_sda = 1'b1;
   logic [7:0] cfg_addr = 8'h68;
   logic [6:0] cfg_mask = 7'h7F;
   logic       ack_en = 1'b1;
   logic       clr = 1'b0;
   logic       sda_pull, flag;
   logic [7:0] data;
   logic       sda_bus;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic       ack;
      logic       flg;
      logic [7:0] dat;
      string      tag;
   } item_t;

   item_t exp_q[$];
   item_t obs;
   event  obs_ev;

   always #4 clk = ~clk;

   assign sda_bus = m_sda & ~sda_pull;

   smb_addr_match dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (m_scl),
      .sda_i       (sda_bus),
      .cfg_addr_i  (cfg_addr),
      .cfg_mask_i  (cfg_mask),
      .hw_ack_en_i (ack_en),
      .flag_clr_i  (clr),
      .sda_pull_o  (sda_pull),
      .flag_o      (flag),
      .data_o      (data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic bus_rstart();
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_sda = 1'b1; wq(Q);
   endtask

   task automatic pulse_clr();
      clr = 1'b1; wq(1);
      clr = 1'b0; wq(2);
   endtask

   // driver: clocks one byte, pushes the expected result, captures the observation
   task automatic send_byte(input logic [7:0] b, input logic e_ack, input logic e_flg,
                            input logic [7:0] e_dat, input string tag, input bit do_clr);
      item_t e;
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wq(Q);
         m_scl = 1'b1; wq(2*Q);
         m_scl = 1'b0; wq(Q);
      end
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      e.ack = e_ack; e.flg = e_flg; e.dat = e_dat; e.tag = tag;
      exp_q.push_back(e);
      obs.ack = ~sda_bus; obs.flg = flag; obs.dat = data; obs.tag = tag;
      -> obs_ev;
      wq(Q);
      m_scl = 1'b0; wq(Q);
      check({tag, " R12 release"}, sda_pull, 1'b0);
      if (do_clr) pulse_clr();
   endtask

   // monitor: pops expected items and compares with what was observed
   initial begin
      forever begin
         @(obs_ev);
         if (exp_q.size() == 0) begin
            check("scoreboard underflow", 1, 0);
         end else begin
            item_t e;
            e = exp_q.pop_front();
            check({e.tag, " ack"},  obs.ack, e.ack);
            check({e.tag, " flag"}, obs.flg, e.flg);
            check({e.tag, " data"}, obs.dat, e.dat);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wq(5);
      check("R1 flag", flag, 1'b0);
      check("R1 data", data, 8'h00);
      check("R1 pull", sda_pull, 1'b0);
      rst_n = 1'b1;
      wq(5);
      check("R1 flag after release", flag, 1'b0);

      // exact address 0x34, write, then data bytes
      cfg_addr = 8'h68; cfg_mask = 7'h7F; ack_en = 1'b1;
      bus_start();
      send_byte(8'h68, 1, 1, 8'h68, "R2 addr 0x34", 1);
      send_byte(8'hA5, 1, 1, 8'hA5, "R6 msb first", 1);
      send_byte(8'h3C, 1, 1, 8'h3C, "R7 data", 1);
      bus_stop(); wq(5);
      check("R9 stop after accepted", flag, 1'b1);
      pulse_clr();
      check("R10 cleared", flag, 1'b0);

      // flag held without clear
      bus_start();
      send_byte(8'h68, 1, 1, 8'h68, "R10 addr", 0);
      wq(400);
      check("R10 held", flag, 1'b1);
      pulse_clr();
      check("R10 clear pulse", flag, 1'b0);
      bus_stop(); wq(5); pulse_clr();

      // mismatch followed by data
      bus_start();
      send_byte(8'h6A, 0, 0, 8'h6A, "R3 mismatch", 1);
      send_byte(8'h11, 0, 0, 8'h6A, "R3 ignored data", 1);
      bus_stop(); wq(5);
      check("R9 stop after ignored", flag, 1'b0);

      // masked ranges
      cfg_mask = 7'h7E;
      bus_start();
      send_byte(8'h6A, 1, 1, 8'h6A, "R4 0x35 mask 7E", 1);
      bus_stop(); wq(5); pulse_clr();
      cfg_addr = 8'hE0; cfg_mask = 7'h73;
      bus_start();
      send_byte(8'hE8, 1, 1, 8'hE8, "R4 0x74", 1);
      bus_stop(); wq(5); pulse_clr();
      bus_start();
      send_byte(8'hF8, 1, 1, 8'hF8, "R4 0x7C", 1);
      bus_stop(); wq(5); pulse_clr();
      bus_start();
      send_byte(8'hE2, 0, 0, 8'hE2, "R4 0x71", 1);
      bus_stop(); wq(5);
      bus_start();
      send_byte(8'hE4, 0, 0, 8'hE4, "R4 0x72", 1);
      bus_stop(); wq(5);

      // general call
      cfg_addr = 8'hE1;
      bus_start();
      send_byte(8'h00, 1, 1, 8'h00, "R5 gc on", 1);
      bus_stop(); wq(5); pulse_clr();
      cfg_addr = 8'hE0;
      bus_start();
      send_byte(8'h00, 0, 0, 8'h00, "R5 gc off", 1);
      bus_stop(); wq(5);

      // repeated start after ignored address
      cfg_addr = 8'h68; cfg_mask = 7'h7F;
      bus_start();
      send_byte(8'h22, 0, 0, 8'h22, "R11 first ignored", 1);
      bus_rstart();
      send_byte(8'h68, 1, 1, 8'h68, "R11 after Sr", 1);
      send_byte(8'h5A, 1, 1, 8'h5A, "R11 data", 1);
      bus_stop(); wq(5); pulse_clr();

      // read transfer
      bus_start();
      send_byte(8'h69, 1, 1, 8'h69, "R13 read addr", 1);
      send_byte(8'hFF, 0, 0, 8'h69, "R13 read byte", 1);
      bus_stop(); wq(5);
      check("R13 stop flags", flag, 1'b1);
      pulse_clr();

      // hardware acknowledge off
      ack_en = 1'b0;
      bus_start();
      send_byte(8'h68, 0, 1, 8'h68, "R8 addr", 1);
      send_byte(8'h77, 0, 1, 8'h77, "R8 data", 1);
      bus_stop(); wq(5); pulse_clr();
      bus_start();
      send_byte(8'h22, 0, 1, 8'h22, "R8 any addr", 1);
      bus_stop(); wq(5); pulse_clr();

      wq(10);
      check("scoreboard drained", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule